// File: doc/BRIEF.md
# Controller Status Register with Wake-Cause Tracking

This block is the status byte of a small 8-bit controller core. It keeps the three arithmetic flags that the ALU reports: carry, half carry and zero. It keeps two sticky bits that record why the core last started running. It also holds the page selects that steer register-file decoding: a one-bit control-register page and a two-bit operational-register page. The read value is a single byte, and the page selects are also driven straight to the register-file decoders.

The two cause bits cannot be written by software. They move only on four events: power-on, the sleep instruction, the watchdog-clear instruction and a watchdog time-out. After a wake, the firmware reads the pair to tell the four start-up cases apart. A pulse on the external reset pin clears the page selects and arithmetic flags but keeps the cause bits, so a pin wake from sleep is still visible. The watchdog counter and the ALU are separate blocks that only supply event strobes and flag values.

Top module: `core_status_reg`

## Requirements
- R1: Asserting the power-on reset (`por_n` low) forces the status byte to 8'h18, meaning both cause bits are 1 and every other bit is 0, at once and without waiting for a clock.
- R2: A sleep strobe with no time-out in the same cycle makes the time-out bit (bit 4) 1 and the power-down bit (bit 3) 0 after the next clock edge.
- R3: A watchdog-clear strobe alone makes both bit 4 and bit 3 equal to 1 after the next clock edge.
- R4: A watchdog time-out clears bit 4 after the next clock edge. With no instruction strobe in the same cycle, bit 3 keeps its value. The resulting (bit4,bit3) codes are 00 for a time-out during sleep and 01 for a time-out while running.
- R5: While `pin_rst_n` is sampled low, bits 4:3 hold their value, bits 7:5 and 2:0 become 0, and every other input in that cycle is ignored. A pin wake from sleep therefore reads (bit4,bit3) = 10.
- R6: A software write loads bits 7:5 and 2:0 from the write data on the next edge. Bits 4:3 of the write data have no effect.
- R7: For each arithmetic flag, meaning carry at bit 0, half carry at bit 1 and zero at bit 2, an asserted ALU enable loads that flag from the ALU value. The ALU value wins over a software write to the same bit in the same cycle.
- R8: `rpage_o` always equals status bits 7:6 (encoding 00 to 11 for pages 0 to 3). `cpage_o` always equals bit 5 (0 selects control page 0, 1 selects page 1).
- R9: When strobes coincide, the time-out has the last word on bit 4, so bit 4 becomes 0. On bit 3 sleep beats watchdog-clear, so sleep plus clear gives (bit4,bit3) = 10, and time-out plus clear gives 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | External reset pin, active low, sampled on the clock |
| sleep_i | input | 1 | One-cycle strobe: sleep instruction executed |
| wdt_clr_i | input | 1 | One-cycle strobe: watchdog-clear instruction executed |
| wdt_to_i | input | 1 | One-cycle strobe: watchdog counter expired |
| sw_we_i | input | 1 | Software write enable for the status byte |
| sw_wdata_i | input | 8 | Software write data |
| alu_we_i | input | 3 | Per-flag ALU update enables (bit0 carry, bit1 half carry, bit2 zero) |
| alu_flags_i | input | 3 | ALU flag values, same bit order |
| status_o | output | 8 | Current status byte |
| rpage_o | output | 2 | Operational-register page select |
| cpage_o | output | 1 | Control-register page select |

## Verification
The bound checker watches every cycle for the effect of each event strobe on the two cause bits. It also checks that the cause bits stay put when no event occurs, that a pin reset holds them while clearing the pages, that each ALU enable loads its flag, and that the page outputs track the byte. Only the bench scenarios show whole wake sequences. Examples are sleep followed by a time-out or by a pin wake, which must leave the 00 and 10 codes. The bench also covers the immediate effect of an asynchronous power-on in mid-run and the exact result of coinciding strobes and write/ALU conflicts, all of which it compares against a behavioural model on every clock.

// File: rtl/status_pkg.sv
package status_pkg;
   // bit positions of the status byte; firmware and the register-file decoder rely on them
   localparam int FLAG_N     = 3;
   localparam int CARRY_BIT  = 0;
   localparam int HCARRY_BIT = 1;
   localparam int ZERO_BIT   = 2;
   localparam int PD_BIT     = 3;
   localparam int TO_BIT     = 4;
   localparam int CPAGE_BIT  = 5;
   localparam int RPAGE_LSB  = 6;

   typedef struct packed {
      logic sleep;
      logic wdt_clr;
      logic wdt_to;
   } wake_evt_t;
endpackage

// File: rtl/status_arith_flags.sv
module status_arith_flags #(
   parameter int NFLAG      = 3,
   parameter bit PIN_CLEARS = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             pin_rst_n,
   input  logic             sw_we,
   input  logic [NFLAG-1:0] sw_flags,
   input  logic [NFLAG-1:0] alu_we,
   input  logic [NFLAG-1:0] alu_flags,
   output logic [NFLAG-1:0] flags_q
);
   for (genvar i = 0; i < NFLAG; i++) begin : g_bit
      logic q;
      logic nxt;

      // ALU enable is applied last so it overrides a software write
      always_comb begin
         nxt = q;
         if (sw_we)     nxt = sw_flags[i];
         if (alu_we[i]) nxt = alu_flags[i];
      end

      if (PIN_CLEARS) begin : g_clr
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)          q <= 1'b0;
            else if (!pin_rst_n) q <= 1'b0;
            else                 q <= nxt;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)         q <= 1'b0;
            else if (pin_rst_n) q <= nxt;
         end
      end

      assign flags_q[i] = q;
   end
endmodule

// File: rtl/status_wake_cause.sv
module status_wake_cause
   import status_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      pin_rst_n,
   input  wake_evt_t evt,
   output logic      to_q,
   output logic      pd_q
);
   logic to_nxt;
   logic pd_nxt;

   always_comb begin
      to_nxt = to_q;
      if (evt.sleep || evt.wdt_clr) to_nxt = 1'b1;
      if (evt.wdt_to)               to_nxt = 1'b0;
      pd_nxt = pd_q;
      if (evt.wdt_clr)              pd_nxt = 1'b1;
      if (evt.sleep)                pd_nxt = 1'b0;
   end

   // a pin reset freezes the cause bits; only power-on forces them
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else if (pin_rst_n) begin
         to_q <= to_nxt;
         pd_q <= pd_nxt;
      end
   end
endmodule

// File: rtl/status_page_sel.sv
module status_page_sel #(
   parameter int RPAGE_W = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               pin_rst_n,
   input  logic               sw_we,
   input  logic               sw_cpage,
   input  logic [RPAGE_W-1:0] sw_rpage,
   output logic               cpage_q,
   output logic [RPAGE_W-1:0] rpage_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cpage_q <= 1'b0;
         rpage_q <= '0;
      end else if (!pin_rst_n) begin
         cpage_q <= 1'b0;
         rpage_q <= '0;
      end else if (sw_we) begin
         cpage_q <= sw_cpage;
         rpage_q <= sw_rpage;
      end
   end
endmodule

// File: rtl/core_status_reg.sv
module core_status_reg
   import status_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RPAGE_W     = 2,
   parameter bit PIN_CLR_ALU = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               pin_rst_n,
   input  logic               sleep_i,
   input  logic               wdt_clr_i,
   input  logic               wdt_to_i,
   input  logic               sw_we_i,
   input  logic [DATA_W-1:0]  sw_wdata_i,
   input  logic [FLAG_N-1:0]  alu_we_i,
   input  logic [FLAG_N-1:0]  alu_flags_i,
   output logic [DATA_W-1:0]  status_o,
   output logic [RPAGE_W-1:0] rpage_o,
   output logic               cpage_o
);
   localparam int LAYOUT_W = RPAGE_LSB + RPAGE_W;

   if (DATA_W != LAYOUT_W) begin : g_bad_width
      $error("core_status_reg: DATA_W must equal RPAGE_LSB + RPAGE_W");
   end
   if (RPAGE_W < 1) begin : g_bad_rpage
      $error("core_status_reg: RPAGE_W must be at least 1");
   end

   logic [FLAG_N-1:0]  flags_q;
   logic               to_q;
   logic               pd_q;
   logic               cpage_q;
   logic [RPAGE_W-1:0] rpage_q;
   wake_evt_t          evt;
   logic               unused_cause_wdata;

   assign evt.sleep   = sleep_i;
   assign evt.wdt_clr = wdt_clr_i;
   assign evt.wdt_to  = wdt_to_i;
   assign unused_cause_wdata = ^sw_wdata_i[TO_BIT:PD_BIT];

   status_arith_flags #(.NFLAG(FLAG_N), .PIN_CLEARS(PIN_CLR_ALU)) u_flags (
      .clk       (clk),
      .por_n     (por_n),
      .pin_rst_n (pin_rst_n),
      .sw_we     (sw_we_i),
      .sw_flags  (sw_wdata_i[FLAG_N-1:0]),
      .alu_we    (alu_we_i),
      .alu_flags (alu_flags_i),
      .flags_q   (flags_q)
   );

   status_wake_cause u_cause (
      .clk       (clk),
      .por_n     (por_n),
      .pin_rst_n (pin_rst_n),
      .evt       (evt),
      .to_q      (to_q),
      .pd_q      (pd_q)
   );

   status_page_sel #(.RPAGE_W(RPAGE_W)) u_page (
      .clk       (clk),
      .por_n     (por_n),
      .pin_rst_n (pin_rst_n),
      .sw_we     (sw_we_i),
      .sw_cpage  (sw_wdata_i[CPAGE_BIT]),
      .sw_rpage  (sw_wdata_i[RPAGE_LSB +: RPAGE_W]),
      .cpage_q   (cpage_q),
      .rpage_q   (rpage_q)
   );

   assign status_o[FLAG_N-1:0]            = flags_q;
   assign status_o[PD_BIT]                = pd_q;
   assign status_o[TO_BIT]                = to_q;
   assign status_o[CPAGE_BIT]             = cpage_q;
   assign status_o[RPAGE_LSB +: RPAGE_W]  = rpage_q;
   assign rpage_o                         = rpage_q;
   assign cpage_o                         = cpage_q;
endmodule

// File: rtl/core_status_chk.sv
module core_status_chk
   import status_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int RPAGE_W = 2
) (
   input logic               clk,
   input logic               por_n,
   input logic               pin_rst_n,
   input logic               sleep_i,
   input logic               wdt_clr_i,
   input logic               wdt_to_i,
   input logic               sw_we_i,
   input logic [DATA_W-1:0]  sw_wdata_i,
   input logic [FLAG_N-1:0]  alu_we_i,
   input logic [FLAG_N-1:0]  alu_flags_i,
   input logic [DATA_W-1:0]  status_o,
   input logic [RPAGE_W-1:0] rpage_o,
   input logic               cpage_o
);
   logic unused_chk_wdata;
   assign unused_chk_wdata = ^sw_wdata_i[TO_BIT:0];

   p_sleep_r2: assert property (@(posedge clk) disable iff (!por_n)
      (pin_rst_n && sleep_i && !wdt_to_i) |=> (status_o[TO_BIT] && !status_o[PD_BIT]));

   p_wdtclr_r3: assert property (@(posedge clk) disable iff (!por_n)
      (pin_rst_n && wdt_clr_i && !sleep_i && !wdt_to_i) |=> (status_o[TO_BIT] && status_o[PD_BIT]));

   p_timeout_r4: assert property (@(posedge clk) disable iff (!por_n)
      (pin_rst_n && wdt_to_i) |=> !status_o[TO_BIT]);

   p_timeout_pd_r4: assert property (@(posedge clk) disable iff (!por_n)
      (pin_rst_n && wdt_to_i && !sleep_i && !wdt_clr_i) |=> $stable(status_o[PD_BIT]));

   p_pin_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
      !pin_rst_n |=> ($stable(status_o[TO_BIT:PD_BIT]) && rpage_o == '0 && !cpage_o));

   p_cause_ro_r6: assert property (@(posedge clk) disable iff (!por_n)
      (pin_rst_n && !sleep_i && !wdt_clr_i && !wdt_to_i) |=> $stable(status_o[TO_BIT:PD_BIT]));

   p_wr_page_r6: assert property (@(posedge clk) disable iff (!por_n)
      (pin_rst_n && sw_we_i) |=> (rpage_o == $past(sw_wdata_i[RPAGE_LSB +: RPAGE_W])
                                  && cpage_o == $past(sw_wdata_i[CPAGE_BIT])));

   for (genvar i = 0; i < FLAG_N; i++) begin : g_alu
      p_alu_r7: assert property (@(posedge clk) disable iff (!por_n)
         (pin_rst_n && alu_we_i[i]) |=> (status_o[i] == $past(alu_flags_i[i])));
   end

   p_page_view_r8: assert property (@(posedge clk) disable iff (!por_n)
      (rpage_o == status_o[RPAGE_LSB +: RPAGE_W]) && (cpage_o == status_o[CPAGE_BIT]));
endmodule

bind core_status_reg core_status_chk #(.DATA_W(DATA_W), .RPAGE_W(RPAGE_W)) u_status_chk (
   .clk         (clk),
   .por_n       (por_n),
   .pin_rst_n   (pin_rst_n),
   .sleep_i     (sleep_i),
   .wdt_clr_i   (wdt_clr_i),
   .wdt_to_i    (wdt_to_i),
   .sw_we_i     (sw_we_i),
   .sw_wdata_i  (sw_wdata_i),
   .alu_we_i    (alu_we_i),
   .alu_flags_i (alu_flags_i),
   .status_o    (status_o),
   .rpage_o     (rpage_o),
   .cpage_o     (cpage_o)
);

// File: tb/tb_core_status_reg.sv
module tb_core_status_reg;
   logic       clk = 1'b0;
   logic       por_n, pin_rst_n, sleep_i, wdt_clr_i, wdt_to_i, sw_we_i;
   logic [7:0] sw_wdata_i;
   logic [2:0] alu_we_i, alu_flags_i;
   logic [7:0] status_o;
   logic [1:0] rpage_o;
   logic       cpage_o;

   int         n_run  = 0;
   int         n_fail = 0;
   logic [7:0] m;   // reference status byte

   always #5 clk = ~clk;

   core_status_reg dut (
      .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .sleep_i(sleep_i),
      .wdt_clr_i(wdt_clr_i), .wdt_to_i(wdt_to_i), .sw_we_i(sw_we_i),
      .sw_wdata_i(sw_wdata_i), .alu_we_i(alu_we_i), .alu_flags_i(alu_flags_i),
      .status_o(status_o), .rpage_o(rpage_o), .cpage_o(cpage_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      pin_rst_n = 1'b1; sleep_i = 1'b0; wdt_clr_i = 1'b0; wdt_to_i = 1'b0;
      sw_we_i = 1'b0; sw_wdata_i = 8'h00; alu_we_i = 3'b000; alu_flags_i = 3'b000;
   endtask

   // behavioural model of one clock edge, from the requirements
   task automatic model_edge();
      logic t, p;
      if (!pin_rst_n) begin
         m[7:5] = 3'b000;
         m[2:0] = 3'b000;
      end else begin
         t = m[4];
         p = m[3];
         if (sleep_i || wdt_clr_i) t = 1'b1;
         if (wdt_to_i) t = 1'b0;
         if (wdt_clr_i) p = 1'b1;
         if (sleep_i) p = 1'b0;
         if (sw_we_i) begin
            m[7:5] = sw_wdata_i[7:5];
            m[2:0] = sw_wdata_i[2:0];
         end
         for (int i = 0; i < 3; i++) if (alu_we_i[i]) m[i] = alu_flags_i[i];
         m[4] = t;
         m[3] = p;
      end
   endtask

   // inputs were driven at the previous falling edge; pass one rising edge, compare at the next fall
   task automatic cyc(string tag);
      @(negedge clk);
      model_edge();
      chk(tag, status_o, m);
      chk({tag, " R8"}, {rpage_o, cpage_o}, {status_o[7:6], status_o[5]});
      idle();
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 power-on value", status_o, 8'h18);
      m = 8'h18;
      por_n = 1'b1;

      // R6: write everything, cause bits must not move
      sw_we_i = 1'b1; sw_wdata_i = 8'hE7; cyc("R6 write E7");
      sw_we_i = 1'b1; sw_wdata_i = 8'h00; cyc("R6 write 00");
      chk("R6 cause bits ignore write", status_o[4:3], 2'b11);
      sw_we_i = 1'b1; sw_wdata_i = 8'h80; cyc("R6 page 2");
      chk("R8 rpage value", rpage_o, 2'b10);

      // R7: ALU beats write on enabled bits
      sw_we_i = 1'b1; sw_wdata_i = 8'h02; alu_we_i = 3'b101; alu_flags_i = 3'b001;
      cyc("R7 alu vs write");
      chk("R7 flags", status_o[2:0], 3'b011);
      alu_we_i = 3'b010; alu_flags_i = 3'b000; cyc("R7 alu only");

      // R2 then R4: time-out during sleep gives 00
      sleep_i = 1'b1; cyc("R2 sleep");
      chk("R2 code 10", status_o[4:3], 2'b10);
      wdt_to_i = 1'b1; cyc("R4 wake by time-out");
      chk("R4 code 00", status_o[4:3], 2'b00);

      // R3 then R4: time-out while running gives 01
      wdt_clr_i = 1'b1; cyc("R3 clear");
      chk("R3 code 11", status_o[4:3], 2'b11);
      wdt_to_i = 1'b1; cyc("R4 running time-out");
      chk("R4 code 01", status_o[4:3], 2'b01);

      // R5: sleep, then pin wake gives 10 and clears pages/flags
      sw_we_i = 1'b1; sw_wdata_i = 8'hFF; cyc("R6 fill");
      sleep_i = 1'b1; cyc("R2 sleep again");
      pin_rst_n = 1'b0; wdt_clr_i = 1'b1; sw_we_i = 1'b1; sw_wdata_i = 8'hFF;
      alu_we_i = 3'b111; alu_flags_i = 3'b111;
      cyc("R5 pin reset");
      chk("R5 pin wake", status_o, 8'h10);

      // R9: coinciding strobes
      sleep_i = 1'b1; wdt_clr_i = 1'b1; cyc("R9 sleep+clear");
      chk("R9 sleep+clear code", status_o[4:3], 2'b10);
      wdt_to_i = 1'b1; wdt_clr_i = 1'b1; cyc("R9 timeout+clear");
      chk("R9 timeout+clear code", status_o[4:3], 2'b01);
      wdt_to_i = 1'b1; sleep_i = 1'b1; cyc("R9 timeout+sleep");
      chk("R9 timeout+sleep code", status_o[4:3], 2'b00);

      // mixed stimulus compared against the model every clock
      for (int k = 0; k < 600; k++) begin
         pin_rst_n   = ($urandom_range(0, 15) != 0);
         sleep_i     = ($urandom_range(0, 7) == 0);
         wdt_clr_i   = ($urandom_range(0, 7) == 0);
         wdt_to_i    = ($urandom_range(0, 7) == 0);
         sw_we_i     = ($urandom_range(0, 3) == 0);
         sw_wdata_i  = 8'($urandom);
         alu_we_i    = 3'($urandom);
         alu_flags_i = 3'($urandom);
         cyc("R2 R3 R4 R5 R6 R7 R9 mixed");
      end

      // R1: asynchronous power-on in mid-run
      sw_we_i = 1'b1; sw_wdata_i = 8'hE5; cyc("R6 before por");
      #2 por_n = 1'b0;
      #1 chk("R1 async por", status_o, 8'h18);
      m = 8'h18;
      @(negedge clk);
      por_n = 1'b1;
      cyc("R1 after por");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule